// File: doc/BRIEF.md
# Coprocessor Program Memory Loader

This block lets a host processor fill the program store of a small embedded coprocessor and read it back, one byte at a time, through four byte-wide registers. An internal pointer selects the program byte. The host writes a data port to store a byte or reads another data port to fetch one. After each such access the pointer steps forward by one unless stepping is switched off. A control register can hold the pointer at zero (the host sets the bit and then clears it to rewind), stop the automatic step, choose between upload and run mode, and keep the coprocessor in reset. A status register passes the coprocessor's boot status byte through to the host.

A typical install sequence keeps the coprocessor in reset in upload mode, rewinds the pointer, streams the image into the data-write port, rewinds again and reads the image back to verify it. It then sets run mode and finally releases the reset. The program store is a synchronous single-write RAM with a second read port through which the coprocessor fetches its code.

Top module: `cpl_loader`

## Requirements
- R1: A host write to register 1 (data-write) stores `bus_wdata` into the program byte at the pointer when the write is accepted (see R8).
- R2: A host read of any register raises `bus_rvalid` for exactly the following cycle with the data on `bus_rdata`. A read of register 2 (data-read) returns the program byte at the pointer. A read of register 1 returns 0x00 and leaves the pointer unchanged.
- R3: While control bit 0 (rewind) is 1, the pointer is held at 0, including in the cycle after the control write that sets the bit.
- R4: While control bit 1 (step-off) is 1, accepted data writes and data-read accesses leave the pointer unchanged.
- R5: Register 0 (control) holds rewind in bit 0, step-off in bit 1, run mode in bit 2 (0 = upload, 1 = run) and reset-hold in bit 3. Bits 7:4 read as 0. `cop_reset_o` equals bit 3, and a read of register 0 returns the current value.
- R6: A read of register 3 (status) returns the value `cop_boot_status` had in the cycle of the read.
- R7: When step-off and rewind are both 0, each accepted data write and each data-read access advances the pointer by one. The pointer wraps from DEPTH-1 to 0.
- R8: A data write is accepted only when run mode is 0 and reset-hold is 1. Otherwise it changes neither the program store nor the pointer.
- R9: After reset the pointer is 0, the control register reads 0x08 and `cop_reset_o` is 1.
- R10: `cop_fetch_data` shows the program byte at `cop_fetch_addr` from the previous cycle. When a write to the same byte happens in that cycle, it shows the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Host access this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register select: 0 control, 1 data-write, 2 data-read, 3 status |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read |
| cop_boot_status | input | 8 | Boot status byte from the coprocessor |
| cop_reset_o | output | 1 | Holds the coprocessor in reset when 1 |
| cop_fetch_addr | input | ADDR_W | Coprocessor code fetch address |
| cop_fetch_data | output | 8 | Fetched code byte, one cycle later |

## Verification
The bench fills the whole store, which forces the pointer through its wrap. A pointer that stopped at DEPTH-1 or ran past it would then return the wrong byte on the first read-back. Rewind is tested by setting and clearing the bit with no access in between. A design that applied rewind one cycle late, or only on a data access, would resume reading from the old position. Writes are attempted in run mode and with reset released. A design that ignored the gate would corrupt stored bytes that a later read-back exposes, or would move the pointer and shift every later read by one. Step-off is tested with repeated reads and writes that must all land on one byte. Reads of the write-only port check that a stray step is not made.

// File: rtl/cpl_pkg.sv
package cpl_pkg;

    typedef enum logic [1:0] {
        REG_CTRL   = 2'd0,
        REG_WDATA  = 2'd1,
        REG_RDATA  = 2'd2,
        REG_STATUS = 2'd3
    } reg_sel_e;

    // packed MSB first: hold is bit 3, rewind is bit 0
    typedef struct packed {
        logic hold;
        logic run;
        logic noinc;
        logic rewind;
    } ctrl_t;

    localparam ctrl_t CTRL_RST = '{hold: 1'b1, run: 1'b0, noinc: 1'b0, rewind: 1'b0};

endpackage

// File: rtl/cpl_regs.sv
module cpl_regs
    import cpl_pkg::*;
#(
    parameter int DEPTH  = 512,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [1:0]        bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [ADDR_W-1:0] ptr_o,
    output logic              mem_we_o,
    output ctrl_t             ctrl_o,
    output reg_sel_e          rsel_o,
    output logic              rvalid_o
);

    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

    typedef struct packed {
        logic [ADDR_W-1:0] ptr;
        ctrl_t             ctrl;
        reg_sel_e          rsel;
        logic              rvalid;
    } state_t;

    state_t s_d, s_q;

    logic is_wr, is_rd, ctrl_wr, data_we, data_re, step;

    always_comb begin
        s_d        = s_q;
        s_d.rvalid = 1'b0;

        is_wr   = bus_valid && bus_write;
        is_rd   = bus_valid && !bus_write;
        ctrl_wr = is_wr && (bus_addr == REG_CTRL);
        data_we = is_wr && (bus_addr == REG_WDATA) && s_q.ctrl.hold && !s_q.ctrl.run;
        data_re = is_rd && (bus_addr == REG_RDATA);
        step    = (data_we || data_re) && !s_q.ctrl.noinc;

        if (ctrl_wr) begin
            s_d.ctrl = ctrl_t'(bus_wdata[3:0]);
        end

        if (is_rd) begin
            s_d.rvalid = 1'b1;
            s_d.rsel   = reg_sel_e'(bus_addr);
        end

        if (s_d.ctrl.rewind) begin
            s_d.ptr = '0;
        end else if (step) begin
            s_d.ptr = (s_q.ptr == LAST) ? '0 : s_q.ptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.ptr    <= '0;
            s_q.ctrl   <= CTRL_RST;
            s_q.rsel   <= REG_CTRL;
            s_q.rvalid <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign ptr_o    = s_q.ptr;
    assign mem_we_o = data_we;
    assign ctrl_o   = s_q.ctrl;
    assign rsel_o   = s_q.rsel;
    assign rvalid_o = s_q.rvalid;

    // R2: every read yields a valid strobe on the next cycle
    a_r2_read_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write) |=> rvalid_o);

    // R3: rewind pins the pointer at zero
    a_r3_rewind_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_o.rewind |-> (ptr_o == '0));

    // R4: with stepping off, pointer only moves through a control write
    a_r4_noinc_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_o.noinc && !(bus_valid && bus_write && bus_addr == REG_CTRL))
        |=> (ptr_o == $past(ptr_o)));

    // R7: accepted access steps by one, with wrap
    a_r7_step_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        ((mem_we_o || (bus_valid && !bus_write && bus_addr == REG_RDATA))
          && !ctrl_o.noinc && !ctrl_o.rewind)
        |=> (($past(ptr_o) == LAST) ? (ptr_o == '0) : (ptr_o == $past(ptr_o) + 1'b1)));

    // R8: a data write in run mode leaves the pointer alone
    a_r8_run_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && bus_addr == REG_WDATA && ctrl_o.run)
        |=> (ptr_o == $past(ptr_o)));

endmodule

// File: rtl/cpl_mem.sv
module cpl_mem #(
    parameter int DEPTH  = 512,
    parameter int ADDR_W = $clog2(DEPTH),
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr_host,
    output logic [DATA_W-1:0] rdata_host,
    input  logic [ADDR_W-1:0] raddr_fetch,
    output logic [DATA_W-1:0] rdata_fetch
);

    logic [DATA_W-1:0] mem_q [DEPTH];

    // read-before-write on both read ports
    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
        rdata_host  <= mem_q[raddr_host];
        rdata_fetch <= mem_q[raddr_fetch];
    end

endmodule

// File: rtl/cpl_loader.sv
module cpl_loader
    import cpl_pkg::*;
#(
    parameter int DEPTH  = 512,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [1:0]        bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              bus_rvalid,
    input  logic [7:0]        cop_boot_status,
    output logic              cop_reset_o,
    input  logic [ADDR_W-1:0] cop_fetch_addr,
    output logic [7:0]        cop_fetch_data
);

    logic [ADDR_W-1:0] ptr;
    logic              mem_we;
    ctrl_t             ctrl;
    reg_sel_e          rsel;
    logic              rvalid;
    logic [7:0]        host_byte;
    logic [7:0]        status_d, status_q;

    cpl_regs #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .ptr_o     (ptr),
        .mem_we_o  (mem_we),
        .ctrl_o    (ctrl),
        .rsel_o    (rsel),
        .rvalid_o  (rvalid)
    );

    cpl_mem #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(8)) u_mem (
        .clk         (clk),
        .we          (mem_we),
        .waddr       (ptr),
        .wdata       (bus_wdata),
        .raddr_host  (ptr),
        .rdata_host  (host_byte),
        .raddr_fetch (cop_fetch_addr),
        .rdata_fetch (cop_fetch_data)
    );

    always_comb begin
        status_d = cop_boot_status;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= '0;
        end else begin
            status_q <= status_d;
        end
    end

    always_comb begin
        bus_rdata = 8'h00;
        if (rvalid) begin
            unique case (rsel)
                REG_CTRL:   bus_rdata = {4'b0000, ctrl};
                REG_WDATA:  bus_rdata = 8'h00;
                REG_RDATA:  bus_rdata = host_byte;
                REG_STATUS: bus_rdata = status_q;
            endcase
        end
    end

    assign bus_rvalid  = rvalid;
    assign cop_reset_o = ctrl.hold;

    // R9: out of reset the coprocessor is held
    a_r9_reset_hold: assert property (@(posedge clk)
        $rose(rst_n) |-> cop_reset_o);

    // R5: releasing the coprocessor needs a control write
    a_r5_release_by_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cop_reset_o) |-> $past(bus_valid && bus_write && bus_addr == REG_CTRL));

endmodule

// File: tb/cpl_loader_tb.sv
module cpl_loader_tb;

    localparam int DEPTH = 512;
    localparam int AW    = $clog2(DEPTH);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_valid = 1'b0;
    logic          bus_write = 1'b0;
    logic [1:0]    bus_addr = 2'd0;
    logic [7:0]    bus_wdata = 8'd0;
    logic [7:0]    bus_rdata;
    logic          bus_rvalid;
    logic [7:0]    cop_boot_status = 8'h00;
    logic          cop_reset_o;
    logic [AW-1:0] cop_fetch_addr = '0;
    logic [7:0]    cop_fetch_data;

    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;
    bit    fetch_ok = 1'b0;
    string cur_tag = "R9";

    // reference model state
    logic [7:0] m_mem [DEPTH];
    int         m_ptr;
    logic [3:0] m_ctrl;
    bit         m_rvalid;
    logic [7:0] m_rdata;
    logic [7:0] m_fetch;

    always #2 clk = ~clk;

    cpl_loader #(.DEPTH(DEPTH)) u_dut (
        .clk             (clk),
        .rst_n           (rst_n),
        .bus_valid       (bus_valid),
        .bus_write       (bus_write),
        .bus_addr        (bus_addr),
        .bus_wdata       (bus_wdata),
        .bus_rdata       (bus_rdata),
        .bus_rvalid      (bus_rvalid),
        .cop_boot_status (cop_boot_status),
        .cop_reset_o     (cop_reset_o),
        .cop_fetch_addr  (cop_fetch_addr),
        .cop_fetch_data  (cop_fetch_data)
    );

    function automatic logic [7:0] pat(int i);
        return 8'((i * 7 + 3) ^ (i >> 3));
    endfunction

    function automatic void m_advance();
        if (m_ctrl[0]) m_ptr = 0;
        else if (!m_ctrl[1]) m_ptr = (m_ptr + 1) % DEPTH;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ptr = 0; m_ctrl = 4'h8; m_rvalid = 0; m_rdata = 8'h00;
        end else begin
            m_fetch  = m_mem[cop_fetch_addr];
            m_rvalid = 0;
            if (bus_valid && bus_write) begin
                case (bus_addr)
                    2'd0: begin m_ctrl = bus_wdata[3:0]; if (m_ctrl[0]) m_ptr = 0; end
                    2'd1: if (m_ctrl[3] && !m_ctrl[2]) begin
                              m_mem[m_ptr] = bus_wdata; m_advance();
                          end
                    default: ;
                endcase
            end else if (bus_valid) begin
                m_rvalid = 1;
                case (bus_addr)
                    2'd0: m_rdata = {4'h0, m_ctrl};
                    2'd1: m_rdata = 8'h00;
                    2'd2: begin m_rdata = m_mem[m_ptr]; m_advance(); end
                    default: m_rdata = cop_boot_status;
                endcase
            end
        end
    end

    task automatic check(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(cur_tag, "rvalid", int'(bus_rvalid), int'(m_rvalid));
            if (m_rvalid) check(cur_tag, "rdata", int'(bus_rdata), int'(m_rdata));
            check("R5", "cop_reset", int'(cop_reset_o), int'(m_ctrl[3]));
            if (fetch_ok) check("R10", "fetch", int'(cop_fetch_data), int'(m_fetch));
        end
    end

    task automatic acc(bit wr, logic [1:0] a, logic [7:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = wr; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) m_mem[i] = 8'h00;
        idle(4);
        @(negedge clk) rst_n = 1'b1;

        // R9: reset state
        cur_tag = "R9";
        check("R9", "cop_reset after reset", int'(cop_reset_o), 1);
        acc(0, 2'd0, 8'h00);
        idle(1);

        // R1, R7: stream the whole store, pointer wraps to 0
        cur_tag = "R1";
        for (int i = 0; i < DEPTH; i++) acc(1, 2'd1, pat(i));
        fetch_ok = 1'b1;
        cur_tag = "R7";
        for (int i = 0; i < 4; i++) acc(0, 2'd2, 8'h00);
        idle(1);

        // R3: rewind strobe with no access in between
        cur_tag = "R3";
        acc(1, 2'd0, 8'h09);
        acc(1, 2'd0, 8'h08);
        for (int i = 0; i < 3; i++) acc(0, 2'd2, 8'h00);
        acc(1, 2'd0, 8'h09);
        acc(0, 2'd2, 8'h00);
        acc(0, 2'd2, 8'h00);
        acc(1, 2'd0, 8'h08);

        // R2: read of write-only port returns 0 and does not step
        cur_tag = "R2";
        acc(0, 2'd1, 8'h00);
        acc(0, 2'd2, 8'h00);
        acc(0, 2'd2, 8'h00);

        // R4: stepping off
        cur_tag = "R4";
        acc(1, 2'd0, 8'h0A);
        for (int i = 0; i < 3; i++) acc(0, 2'd2, 8'h00);
        acc(1, 2'd1, 8'hC3);
        acc(1, 2'd1, 8'h3C);
        acc(0, 2'd2, 8'h00);
        acc(1, 2'd0, 8'h08);
        acc(0, 2'd2, 8'h00);
        acc(0, 2'd2, 8'h00);

        // R8: writes in run mode or with reset released are dropped
        cur_tag = "R8";
        acc(1, 2'd0, 8'h0C);
        acc(1, 2'd1, 8'hEE);
        acc(1, 2'd0, 8'h00);
        acc(1, 2'd1, 8'hDD);
        acc(1, 2'd0, 8'h09);
        acc(1, 2'd0, 8'h08);
        for (int i = 0; i < 4; i++) acc(0, 2'd2, 8'h00);

        // R5: run then release, control readback
        cur_tag = "R5";
        acc(1, 2'd0, 8'h0C);
        acc(0, 2'd0, 8'h00);
        acc(1, 2'd0, 8'hF4);
        acc(0, 2'd0, 8'h00);

        // R6: status passthrough
        cur_tag = "R6";
        cop_boot_status = 8'h5A;
        acc(0, 2'd3, 8'h00);
        cop_boot_status = 8'hA5;
        acc(0, 2'd3, 8'h00);

        // R10: fetch sweep over the store
        cur_tag = "R10";
        for (int i = 0; i < 40; i++) begin
            @(negedge clk) cop_fetch_addr = AW'((i * 37) % DEPTH);
        end
        idle(2);
        finish_run();
    end

endmodule